// File: doc/BRIEF.md
# Serial Peripheral Master with Selectable Chip-Select Release

This block is a single-lane serial peripheral master for use inside a larger chip. Software programs a 32-bit mode word, then writes characters one at a time into a single transmit holding register. The engine shifts each character out on a data-out line and, on the same clock edges, shifts a character in from the data-in line. It drives a serial clock idle-low and samples on the rising edge, most significant bit first. Characters are 8 or 16 bits long, and the serial clock half-period is a fixed number of system clock cycles set by a parameter.

One active-low select line frames the transfers, and the mode word chooses when it is released. The select can stay low for as long as software keeps the holding register topped up. It can stay low until a character tagged as the final one has gone out. Or it can drop after every character. Two programmable counts space the traffic: one sets idle cycles between back-to-back characters under a held select, and the other sets a minimum time the select stays high before it may fall again. An optional gate holds off the next character until software has read the previous received one. An internal loopback ties the data-out line to the sampling input.

The host side is a plain strobe interface. Reads return data combinationally. Side effects happen only on the clock edge where the read strobe is high, so the bench and other logic can observe a register without disturbing it.

Top module: `spi_cs_master`

## Requirements
- R1: After reset the select line (`cs_n`) is high, the serial clock is low, the mode word (address 0) reads 0, and the status word (address 3) reads 1: transmit-empty set, receive-ready clear, overrun clear.
- R2: Characters are sent with the clock idle-low, data sampled on the rising edge, most significant bit first, and each clock phase lasting `HALF_DIV` system cycles. Mode bits 11:8 set the length: the value 8 selects 16 bits and every other value selects 8 bits. The received character appears at address 2, zero-extended.
- R3: When mode bit 1 is set, the engine samples its own data-out line and the external data-in pin has no effect on the received character.
- R4: With mode bits 5:4 equal to 0, the select is released at the end of a character only if the holding register is empty at that moment. Otherwise the next character follows with the select still low.
- R5: With mode bits 5:4 equal to 1, the select stays low across characters, even while no data is waiting. It is released once a character written with transmit-word bit 24 set has been shifted out. The select never rises except at the end of a character.
- R6: With mode bits 5:4 equal to 2 or 3, the select is released after every character.
- R7: When mode bit 2 is set, a character does not start while receive-ready is set. It starts once the received character has been read. When bit 2 is clear, characters start regardless of receive-ready.
- R8: When the next character is already waiting under a held select, it starts exactly G+1 cycles after the previous one ends, where G is mode bits 23:16. The serial clock then stays low for G+1+`HALF_DIV` samples between the two characters.
- R9: After a release the select stays high for at least D+1 cycles, where D is mode bits 31:24. It stays high for exactly D+1 cycles when data is already waiting.
- R10: The registers are at these addresses. Address 0 is the mode word, readable and writable. Address 1 takes a transmit write: data in bits 15:0, final-character tag in bit 24. The write clears transmit-empty, and the start of that character sets transmit-empty again. Address 2 is the received character, and a strobed read clears receive-ready. Address 3 is status: bit 0 transmit-empty, bit 1 receive-ready, bit 2 overrun. A strobed read of status clears overrun.
- R11: Overrun sets when a character completes while receive-ready is still set and no receive read is strobed in that cycle. If a status read is strobed in the same cycle, the set wins.
- R12: If a receive read is strobed in the very cycle a character completes, the read returns the previous character, receive-ready stays set with the new character, and overrun does not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables read side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two pairs of events can land on the same edge. A character can finish and be captured in the cycle where software strobes a read of the receive register. An overrun can set in the cycle where software strobes a read of status. The bench provokes both by waiting for the select to fall and then counting exactly the character length in clock cycles, so the strobe sits on the capture edge. It then judges the outcome at the ports. The read must return the older character, receive-ready must stay set with the new one, and overrun must stay clear. In the second case, overrun must remain set.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  parameter int SPI_DW = 16;
  localparam int SPI_BCW = $clog2(SPI_DW + 1);

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_TX   = 2'd1;
  localparam logic [1:0] A_RX   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam logic [31:0] MODE_WMASK = 32'hFFFF_0F36;
  localparam int TX_LAST_BIT = 24;

  typedef struct packed {
    logic [7:0] cs_idle;
    logic [7:0] char_gap;
    logic [3:0] rsv_hi;
    logic [3:0] len_code;
    logic [1:0] rsv_mid;
    logic [1:0] cs_pol;
    logic       rsv_b3;
    logic       wait_rd;
    logic       lpbk;
    logic       rsv_b0;
  } mode_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_HOLD  = 2'd2
  } seq_st_t;

  function automatic logic [SPI_BCW-1:0] char_len(input logic [3:0] code);
    return (code == 4'd8) ? SPI_BCW'(16) : SPI_BCW'(8);
  endfunction

  function automatic logic cs_release(input logic [1:0] pol,
                                      input logic cur_last,
                                      input logic more_data);
    case (pol)
      2'd0:    return !more_data;
      2'd1:    return cur_last;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [SPI_DW-1:0] left_align(input logic [SPI_DW-1:0] w,
                                                  input logic [SPI_BCW-1:0] n);
    return w << (SPI_DW - int'(n));
  endfunction

endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
  import spi_cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_take,
  input  logic              char_end,
  input  logic [SPI_DW-1:0] rx_word,
  output mode_t             mode_q,
  output logic              tx_full,
  output logic [SPI_DW-1:0] tx_data,
  output logic              tx_last,
  output logic              rx_ready,
  output logic              overrun
);

  logic [SPI_DW-1:0] rx_q;
  logic wr_mode, wr_tx, rd_rx, rd_stat;

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_tx   = reg_wr && (reg_addr == A_TX);
  assign rd_rx   = reg_rd && (reg_addr == A_RX);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= mode_t'(reg_wdata & MODE_WMASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_data <= '0;
      tx_last <= 1'b0;
    end else if (wr_tx) begin
      tx_full <= 1'b1;
      tx_data <= reg_wdata[SPI_DW-1:0];
      tx_last <= reg_wdata[TX_LAST_BIT];
    end else if (tx_take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= '0;
      rx_ready <= 1'b0;
    end else if (char_end) begin
      rx_q     <= rx_word;
      rx_ready <= 1'b1;
    end else if (rd_rx) begin
      rx_ready <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
    end else if (char_end && rx_ready && !rd_rx) begin
      overrun <= 1'b1;
    end else if (rd_stat) begin
      overrun <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_RX:    reg_rdata = {{(32-SPI_DW){1'b0}}, rx_q};
      A_STAT:  reg_rdata = {29'd0, overrun, rx_ready, !tx_full};
      default: reg_rdata = 32'd0;
    endcase
  end

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter
  import spi_cs_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SPI_DW-1:0]  load_word,
  input  logic [SPI_BCW-1:0] nbits,
  input  logic               sample_in,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic               char_end,
  output logic [SPI_DW-1:0]  rx_word
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0]      div_q;
  logic [SPI_BCW-1:0] bit_q;
  logic [SPI_BCW-1:0] nb_q;
  logic [SPI_DW-1:0]  sh_out;
  logic [SPI_DW-1:0]  sh_in;
  logic               div_last;
  logic               last_bit;

  assign div_last = (div_q == DIV_LAST);
  assign last_bit = (bit_q == nb_q - SPI_BCW'(1));
  assign char_end = busy && div_last && sclk && last_bit;
  assign mosi     = sh_out[SPI_DW-1];
  assign rx_word  = sh_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      nb_q   <= '0;
      sh_out <= '0;
      sh_in  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      sclk   <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      nb_q   <= nbits;
      sh_out <= left_align(load_word, nbits);
      sh_in  <= '0;
    end else if (busy) begin
      if (div_last) begin
        div_q <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          sh_in <= {sh_in[SPI_DW-2:0], sample_in};
        end else begin
          sclk   <= 1'b0;
          sh_out <= {sh_out[SPI_DW-2:0], 1'b0};
          if (last_bit) begin
            busy <= 1'b0;
          end else begin
            bit_q <= bit_q + SPI_BCW'(1);
          end
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_full,
  input  logic       tx_last,
  input  logic       rx_ready,
  input  logic       char_end,
  input  logic       wait_rd,
  input  logic [1:0] cs_pol,
  input  logic [7:0] char_gap,
  input  logic [7:0] cs_idle,
  output logic       start,
  output logic       cs_n
);

  seq_st_t    st_q;
  logic [7:0] cnt_q;
  logic       cur_last;
  logic       gate_ok;
  logic       can_go;

  assign gate_ok = !wait_rd || !rx_ready;
  assign can_go  = tx_full && gate_ok && (cnt_q == 8'd0);
  assign start   = ((st_q == SQ_IDLE) || (st_q == SQ_HOLD)) && can_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      cs_n     <= 1'b1;
      cnt_q    <= '0;
      cur_last <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE, SQ_HOLD: begin
          if (start) begin
            st_q     <= SQ_SHIFT;
            cs_n     <= 1'b0;
            cur_last <= tx_last;
          end else if (cnt_q != 8'd0) begin
            cnt_q <= cnt_q - 8'd1;
          end
        end
        SQ_SHIFT: begin
          if (char_end) begin
            if (cs_release(cs_pol, cur_last, tx_full)) begin
              st_q  <= SQ_IDLE;
              cs_n  <= 1'b1;
              cnt_q <= cs_idle;
            end else begin
              st_q  <= SQ_HOLD;
              cnt_q <= char_gap;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);

  mode_t              mode_q;
  logic               tx_full;
  logic [SPI_DW-1:0]  tx_data;
  logic               tx_last;
  logic               rx_ready;
  logic               overrun;
  logic               start;
  logic               busy;
  logic               char_end;
  logic [SPI_DW-1:0]  rx_word;
  logic               sample_in;
  logic [1:0]         csm_w;
  logic               wait_rd_w;
  logic [7:0]         cs_idle_w;
  logic [7:0]         char_gap_w;
  logic [SPI_BCW-1:0] nbits_w;

  assign csm_w      = mode_q.cs_pol;
  assign wait_rd_w  = mode_q.wait_rd;
  assign cs_idle_w  = mode_q.cs_idle;
  assign char_gap_w = mode_q.char_gap;
  assign nbits_w    = char_len(mode_q.len_code);
  assign sample_in  = mode_q.lpbk ? mosi : miso;

  spi_cs_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tx_take   (start),
    .char_end  (char_end),
    .rx_word   (rx_word),
    .mode_q    (mode_q),
    .tx_full   (tx_full),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .rx_ready  (rx_ready),
    .overrun   (overrun)
  );

  spi_cs_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_full  (tx_full),
    .tx_last  (tx_last),
    .rx_ready (rx_ready),
    .char_end (char_end),
    .wait_rd  (wait_rd_w),
    .cs_pol   (csm_w),
    .char_gap (char_gap_w),
    .cs_idle  (cs_idle_w),
    .start    (start),
    .cs_n     (cs_n)
  );

  spi_cs_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_word (tx_data),
    .nbits     (nbits_w),
    .sample_in (sample_in),
    .busy      (busy),
    .sclk      (sclk),
    .mosi      (mosi),
    .char_end  (char_end),
    .rx_word   (rx_word)
  );

endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] reg_addr,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       start,
  input logic       char_end,
  input logic       tx_full,
  input logic       rx_ready,
  input logic       overrun,
  input logic [1:0] csm,
  input logic       wait_rd,
  input logic [7:0] cs_idle
);

  logic [8:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (cs_n) begin
      if (hi_cnt != 9'h1FF) hi_cnt <= hi_cnt + 9'd1;
    end else begin
      hi_cnt <= '0;
    end
  end

  assert_busy_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mode0_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_end && csm == 2'd0 && tx_full) |=> !cs_n);

  assert_mode0_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_end && csm == 2'd0 && !tx_full) |=> cs_n);

  assert_release_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !char_end) |=> !cs_n);

  assert_every_char_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_end && csm[1]) |=> cs_n);

  assert_wait_read_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && wait_rd) |-> !rx_ready);

  assert_cs_idle_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= ({1'b0, cs_idle} + 9'd1)));

  assert_tx_empty_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(reg_wr && reg_addr == 2'd1)) |=> !tx_full);

  assert_overrun_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (char_end && rx_ready && !(reg_rd && reg_addr == 2'd2)) |=> overrun);

  assert_capture_beats_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (char_end && reg_rd && reg_addr == 2'd2) |=> rx_ready);

endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .busy     (busy),
  .start    (start),
  .char_end (char_end),
  .tx_full  (tx_full),
  .rx_ready (rx_ready),
  .overrun  (overrun),
  .csm      (csm_w),
  .wait_rd  (wait_rd_w),
  .cs_idle  (cs_idle_w)
);

// File: tb/tb_spi_cs_master.sv
`timescale 1ns/1ps
module tb_spi_cs_master;

  localparam int HALF = 2;
  localparam int CH8  = 2 * HALF * 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        sclk, mosi, cs_n;
  logic        miso;

  int checks = 0;
  int errors = 0;

  logic [15:0] slv_tx = 16'h0000;
  logic [15:0] slv_sh = 16'h0000;
  logic [15:0] mosi_cap = 16'h0000;
  logic        prev_sclk = 1'b0;
  logic        prev_cs = 1'b1;
  int          rises = 0;
  int          falls = 0;

  always #4 clk = ~clk;

  spi_cs_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  assign miso = slv_sh[15];

  always @(negedge clk) begin
    if (cs_n) slv_sh <= slv_tx;
    else if (prev_sclk && !sclk) slv_sh <= {slv_sh[14:0], 1'b0};
    if (!prev_sclk && sclk) begin
      rises    <= rises + 1;
      mosi_cap <= {mosi_cap[14:0], mosi};
    end
    if (prev_cs && !cs_n) falls <= falls + 1;
    prev_sclk <= sclk;
    prev_cs   <= cs_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    logic [31:0] d;
    rd(2'd2, d);
    rd(2'd3, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 sclk", {31'd0, sclk}, 32'd0);
    peek(2'd0, d); chk("R1 mode", d, 32'd0);
    peek(2'd3, d); chk("R1 status", d, 32'd1);
  endtask

  task automatic t_loop8();
    logic [31:0] d;
    int r0;
    slv_tx = 16'h0000;
    wr(2'd0, 32'h0000_0022);
    r0 = rises;
    wr(2'd1, 32'h0000_00A5);
    idle(CH8 + 10);
    peek(2'd2, d); chk("R3 loopback ignores pin", d, 32'h0000_00A5);
    chk("R2 eight clocks", rises - r0, 8);
    peek(2'd3, d); chk("R10 ready and empty", d, 32'h3);
    rd(2'd2, d);
    peek(2'd3, d); chk("R10 read clears ready", d, 32'h1);
  endtask

  task automatic t_loop16();
    logic [31:0] d;
    int r0;
    wr(2'd0, 32'h0000_0822);
    r0 = rises;
    wr(2'd1, 32'h0000_C35A);
    idle(2 * CH8 + 10);
    peek(2'd2, d); chk("R2 16-bit data", d, 32'h0000_C35A);
    chk("R2 sixteen clocks", rises - r0, 16);
    clear_flags();
    wr(2'd0, 32'h0000_0422);
    r0 = rises;
    wr(2'd1, 32'h0000_1234);
    idle(CH8 + 10);
    peek(2'd2, d); chk("R2 other code is 8-bit", d, 32'h0000_0034);
    chk("R2 other code clocks", rises - r0, 8);
    clear_flags();
  endtask

  task automatic t_external();
    logic [31:0] d;
    slv_tx = 16'h3C00;
    wr(2'd0, 32'h0000_0020);
    wr(2'd1, 32'h0000_0081);
    idle(CH8 + 10);
    peek(2'd2, d); chk("R2 msb-first receive", d, 32'h0000_003C);
    chk("R2 msb-first send", {24'd0, mosi_cap[7:0]}, 32'h81);
    clear_flags();
    slv_tx = 16'h0000;
  endtask

  task automatic t_mode2();
    logic [31:0] d;
    int f0, run, last_hi;
    wr(2'd0, 32'h0300_0022);
    f0 = falls;
    wr(2'd1, 32'h0000_0011);
    @(negedge cs_n);
    wr(2'd1, 32'h0000_0022);
    run = 0; last_hi = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (cs_n) run++;
      else begin
        if (run != 0) last_hi = run;
        run = 0;
      end
    end
    chk("R6 select drops per char", falls - f0, 2);
    chk("R9 idle exactly D+1", last_hi, 4);
    peek(2'd3, d); chk("R11 overrun set", d, 32'h7);
    peek(2'd2, d); chk("R11 newest data kept", d, 32'h22);
    rd(2'd3, d);
    peek(2'd3, d); chk("R10 status read clears overrun", d, 32'h3);
    clear_flags();
    wr(2'd0, 32'h0000_0032);
    f0 = falls;
    wr(2'd1, 32'h0000_0033);
    @(negedge cs_n);
    wr(2'd1, 32'h0000_0044);
    idle(3 * CH8);
    chk("R6 code 3 like code 2", falls - f0, 2);
    clear_flags();
  endtask

  task automatic t_mode0();
    int f0, run, mx;
    wr(2'd0, 32'h0005_0002);
    f0 = falls;
    wr(2'd1, 32'h0000_0055);
    @(negedge cs_n);
    wr(2'd1, 32'h0000_0066);
    run = 0; mx = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (!cs_n && !sclk) begin
        run++;
        if (run > mx) mx = run;
      end else run = 0;
    end
    chk("R4 refilled keeps select", falls - f0, 1);
    chk("R8 gap between chars", mx, 5 + 1 + HALF);
    chk("R4 empty releases", {31'd0, cs_n}, 32'd1);
    wr(2'd1, 32'h0000_0077);
    idle(CH8 + 10);
    chk("R4 late write new frame", falls - f0, 2);
    clear_flags();
  endtask

  task automatic t_mode1();
    int f0;
    wr(2'd0, 32'h0000_0012);
    f0 = falls;
    wr(2'd1, 32'h0000_0081);
    idle(CH8 + 30);
    chk("R5 held while starved", {31'd0, cs_n}, 32'd0);
    wr(2'd1, 32'h0100_0082);
    idle(CH8 + 10);
    chk("R5 released after tagged", {31'd0, cs_n}, 32'd1);
    chk("R5 single frame", falls - f0, 1);
    clear_flags();
  endtask

  task automatic t_wait();
    logic [31:0] d;
    int f0;
    wr(2'd0, 32'h0000_0026);
    wr(2'd1, 32'h0000_00A1);
    idle(CH8 + 10);
    f0 = falls;
    wr(2'd1, 32'h0000_00B2);
    idle(CH8 + 30);
    chk("R7 blocked start", falls - f0, 0);
    peek(2'd3, d); chk("R7 holding still full", d, 32'h2);
    rd(2'd2, d); chk("R7 first data", d, 32'hA1);
    idle(CH8 + 10);
    chk("R7 starts after read", falls - f0, 1);
    peek(2'd2, d); chk("R7 second data", d, 32'hB2);
    peek(2'd3, d); chk("R7 no overrun", d, 32'h3);
    clear_flags();
  endtask

  task automatic t_same_cycle();
    logic [31:0] d, got;
    wr(2'd0, 32'h0000_0022);
    wr(2'd1, 32'h0000_00C1);
    idle(CH8 + 10);
    wr(2'd1, 32'h0000_00C2);
    @(negedge cs_n);
    repeat (CH8 - 1) @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd2;
    #1 got = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R12 read returns older", got, 32'hC1);
    peek(2'd3, d); chk("R12 ready kept, no overrun", d, 32'h3);
    peek(2'd2, d); chk("R12 new data held", d, 32'hC2);
    wr(2'd1, 32'h0000_00C3);
    @(negedge cs_n);
    repeat (CH8 - 1) @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 2'd3;
    @(negedge clk);
    reg_rd = 1'b0;
    peek(2'd3, d); chk("R11 set beats clear", d, 32'h7);
    clear_flags();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_loop8();
    t_loop16();
    t_external();
    t_mode2();
    t_mode0();
    t_mode1();
    t_wait();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=expired expected=completed");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule